// File: doc/BRIEF.md
# Randomized Matrix Product Checker

This block decides at run time whether a claimed product C of two square matrices A and B is correct, without forming A times B again. In each round it draws an N-bit 0/1 vector r from a pseudo-random source and forms its complement rc. It evaluates B·r and B·rc, then A·(B·r) and A·(B·rc), and compares these against C·r and C·rc. Every step is a matrix-vector product, so a round costs O(N²) multiply-adds rather than the O(N³) of a full recomputation.

Since r and rc together cover every column, each element of C takes part in exactly one of the two comparisons in every round. A single wrong element of C is therefore caught in the first round, whatever vector was drawn. For the single-vector test alone, k independent rounds leave at most a 1/2^k chance of missing a wrong C. The caller loads the operands, pulses start with a round count and reads a sticky error flag when done pulses. The operand and round inputs must stay stable while busy is high.

Top module: `mat_prod_checker`

## Requirements
- R1: After reset, busy_o, done_o and err_o are all low.
- R2: A start_i seen at a clock edge while idle begins a run. busy_o is high for exactly 2·N·k cycles, where k is rounds_i sampled at that edge; a rounds_i of zero runs one round.
- R3: done_o is high for exactly one cycle, in the first cycle after busy_o falls, and never while busy_o is high.
- R4: When C equals A·B, err_o stays low for the whole run, including when every operand element holds its maximum value. Element (i,j) of each matrix sits at bit offset (i·N+j)·width of its bus.
- R5: When exactly one element (i,j) of C differs from the true product, err_o rises in the first round, in the cycle after the (N+1+i)-th clock edge that follows the start edge, and is high when done_o pulses.
- R6: err_o holds its value until the next accepted start, and that start clears it.
- R7: A start_i seen while busy_o is high has no effect on the run length or on the outputs.
- R8: The random bits come from a 16-bit maximal-length LFSR that never holds zero; each round takes N fresh bits for r, and rc is the bitwise complement of r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check when idle |
| rounds_i | input | RW | Number of rounds k (0 runs one) |
| a_i | input | N·N·AW | Matrix A, row-major |
| b_i | input | N·N·AW | Matrix B, row-major |
| c_i | input | N·N·CW | Claimed product C, row-major |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
The hardest case to reach from the ports is a corruption that one of the two vectors misses, since whether r or rc covers a given column depends on the LFSR state, which the bench cannot see. The stimulus therefore corrupts every one of the N² positions of C in turn, with small, sign-flipping and top-bit errors and with operands at their maximum value, so the column falls under r in some runs and under rc in others. Because detection must not depend on that split, the bench can predict the exact cycle err_o rises from the row index alone.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_VEC, PH_CMP} phase_e;

  // x^16 + x^14 + x^13 + x^11 + 1, maximal length
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/mpc_lfsr.sv
module mpc_lfsr #(
  parameter int          N    = 3,
  parameter logic [15:0] SEED = 16'hace1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [N-1:0] bits_o
);
  logic [15:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    for (int s = 0; s < N; s++) state_d = mpc_pkg::lfsr_next(state_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= state_d;
  end

  assign bits_o = state_q[N-1:0];

  assert_lfsr_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 16'h0);
  assert_lfsr_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> state_q != $past(state_q));
endmodule

// File: rtl/mpc_dot.sv
module mpc_dot #(
  parameter int N  = 3,
  parameter int EW = 8,
  parameter int VW = 1,
  parameter int OW = 20
) (
  input  logic [N*EW-1:0] row_i,
  input  logic [N*VW-1:0] vec_i,
  output logic [OW-1:0]   sum_o
);
  always_comb begin
    sum_o = '0;
    for (int j = 0; j < N; j++)
      sum_o = sum_o + OW'(row_i[j*EW +: EW]) * OW'(vec_i[j*VW +: VW]);
  end
endmodule

// File: rtl/mpc_ctrl.sv
module mpc_ctrl
  import mpc_pkg::*;
#(
  parameter int N  = 3,
  parameter int RW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] rounds_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          vec_ph_o,
  output logic          cmp_ph_o,
  output logic [IW-1:0] row_o,
  output logic          draw_o
);
  phase_e        phase_q;
  logic [IW-1:0] row_q;
  logic [RW-1:0] left_q;
  logic          done_q;
  logic          last_row;

  assign last_row = (row_q == IW'(N - 1));
  assign busy_o   = (phase_q != PH_IDLE);
  assign vec_ph_o = (phase_q == PH_VEC);
  assign cmp_ph_o = (phase_q == PH_CMP);
  assign row_o    = row_q;
  assign done_o   = done_q;
  assign draw_o   = ((phase_q == PH_IDLE) && start_i) ||
                    (cmp_ph_o && last_row && (left_q != RW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_VEC;
          row_q   <= '0;
          left_q  <= (rounds_i == '0) ? RW'(1) : rounds_i;
        end
        PH_VEC: begin
          row_q <= last_row ? '0 : row_q + IW'(1);
          if (last_row) phase_q <= PH_CMP;
        end
        PH_CMP: begin
          row_q <= last_row ? '0 : row_q + IW'(1);
          if (last_row) begin
            if (left_q == RW'(1)) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_VEC;
              left_q  <= left_q - RW'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (vec_ph_o && row_q == '0));
  assert_round_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(cmp_ph_o && last_row)) |=> (left_q == $past(left_q)));
endmodule

// File: rtl/mat_prod_checker.sv
module mat_prod_checker #(
  parameter int N  = 3,
  parameter int AW = 8,
  parameter int CW = 2 * AW + $clog2(N + 1),
  parameter int RW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [RW-1:0]   rounds_i,
  input  logic [N*N*AW-1:0] a_i,
  input  logic [N*N*AW-1:0] b_i,
  input  logic [N*N*CW-1:0] c_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int LW   = $clog2(N + 1);
  localparam int BRW  = AW + LW;
  localparam int ABW  = AW + BRW + LW;
  localparam int CRW  = CW + LW;
  localparam int CMPW = (ABW > CRW) ? ABW : CRW;
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int ROWA = N * AW;
  localparam int ROWC = N * CW;

  logic          vec_ph, cmp_ph, draw;
  logic [IW-1:0] row;
  logic [N-1:0]  rnd_bits, r_q, rc;
  logic [N*BRW-1:0] br_q, brc_q;
  logic [BRW-1:0]   br_d, brc_d;
  logic [CMPW-1:0]  abr, abrc, cr, crc;
  logic [ROWA-1:0]  a_row, b_row;
  logic [ROWC-1:0]  c_row;
  logic             err_q, mismatch;

  mpc_ctrl #(.N(N), .RW(RW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .rounds_i,
    .busy_o, .done_o,
    .vec_ph_o (vec_ph),
    .cmp_ph_o (cmp_ph),
    .row_o    (row),
    .draw_o   (draw)
  );

  mpc_lfsr #(.N(N)) u_lfsr (
    .clk_i, .rst_ni,
    .adv_i  (draw),
    .bits_o (rnd_bits)
  );

  assign rc = ~r_q;

  always_comb begin
    a_row = a_i[int'(row) * ROWA +: ROWA];
    b_row = b_i[int'(row) * ROWA +: ROWA];
    c_row = c_i[int'(row) * ROWC +: ROWC];
  end

  // pass 1: B*r and B*rc, one row per cycle
  mpc_dot #(.N(N), .EW(AW), .VW(1), .OW(BRW)) u_b_r  (.row_i(b_row), .vec_i(r_q), .sum_o(br_d));
  mpc_dot #(.N(N), .EW(AW), .VW(1), .OW(BRW)) u_b_rc (.row_i(b_row), .vec_i(rc),  .sum_o(brc_d));

  // pass 2: A*(B*v) against C*v, one row per cycle
  mpc_dot #(.N(N), .EW(AW), .VW(BRW), .OW(CMPW)) u_a_br  (.row_i(a_row), .vec_i(br_q),  .sum_o(abr));
  mpc_dot #(.N(N), .EW(AW), .VW(BRW), .OW(CMPW)) u_a_brc (.row_i(a_row), .vec_i(brc_q), .sum_o(abrc));
  mpc_dot #(.N(N), .EW(CW), .VW(1),   .OW(CMPW)) u_c_r   (.row_i(c_row), .vec_i(r_q),   .sum_o(cr));
  mpc_dot #(.N(N), .EW(CW), .VW(1),   .OW(CMPW)) u_c_rc  (.row_i(c_row), .vec_i(rc),    .sum_o(crc));

  assign mismatch = cmp_ph && ((abr != cr) || (abrc != crc));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q   <= '0;
      br_q  <= '0;
      brc_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (draw) r_q <= rnd_bits;
      if (vec_ph) begin
        br_q[int'(row) * BRW +: BRW]  <= br_d;
        brc_q[int'(row) * BRW +: BRW] <= brc_d;
      end
      if (start_i && !busy_o) err_q <= 1'b0;
      else if (mismatch)      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(start_i && !busy_o)) |=> err_o);
  assert_err_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !err_o);
  assert_err_in_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(cmp_ph));
  assert_rc_covers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($countones(r_q) + $countones(rc) == N));
endmodule

// File: tb/mat_prod_checker_bench.sv
module mat_prod_checker_bench;
  localparam int N  = 3;
  localparam int AW = 8;
  localparam int CW = 2 * AW + $clog2(N + 1);
  localparam int RW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [RW-1:0] rounds_i = '0;
  logic [N*N*AW-1:0] a_i = '0, b_i = '0;
  logic [N*N*CW-1:0] c_i = '0;
  logic busy_o, done_o, err_o;

  always #2 clk_i = ~clk_i;

  mat_prod_checker #(.N(N), .AW(AW), .CW(CW), .RW(RW)) u_mat_prod_checker (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R4";

  int am[N][N], bm[N][N], cm[N][N];

  // reference model state
  bit m_busy = 0, m_done = 0, m_err = 0;
  int m_cnt = 0, m_tot = 0, m_det = -1;
  bit m_bad = 0;
  int m_row = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_det) m_err = 1;
        if (m_cnt == m_tot) begin m_busy = 0; m_done = 1; end
      end else if (start_i) begin
        m_busy = 1; m_err = 0; m_cnt = 0;
        m_tot = 2 * N * ((rounds_i == 0) ? 1 : int'(rounds_i));
        m_det = m_bad ? (N + 1 + m_row) : -1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check(busy_o == m_busy, "R2 busy", busy_o, m_busy);
      check(done_o == m_done, "R3 done", done_o, m_done);
      check(err_o == m_err, cur_req, err_o, m_err);
    end
  end

  task automatic load(bit bad, int bi, int bj, int mask);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        cm[i][j] = 0;
        for (int t = 0; t < N; t++) cm[i][j] += am[i][t] * bm[t][j];
      end
    if (bad) cm[bi][bj] = (cm[bi][bj] ^ mask) & ((1 << CW) - 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        a_i[(i*N+j)*AW +: AW] = AW'(am[i][j]);
        b_i[(i*N+j)*AW +: AW] = AW'(bm[i][j]);
        c_i[(i*N+j)*CW +: CW] = CW'(cm[i][j]);
      end
    m_bad = bad;
    m_row = bi;
  endtask

  task automatic run(int k, bit bad, int bi, int bj, int mask, bit hold, string req);
    int kk;
    kk = (k == 0) ? 1 : k;
    @(negedge clk_i);
    cur_req = req;
    load(bad, bi, bj, mask);
    rounds_i = RW'(k);
    start_i = 1'b1;
    @(negedge clk_i);
    if (!hold) start_i = 1'b0;
    repeat (2 * N * kk) @(negedge clk_i);
    start_i = 1'b0;
    check(err_o == bad, {req, " final err"}, err_o, bad);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic fill(int seed, bit maxv);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        am[i][j] = maxv ? 255 : ((seed * 37 + i * 11 + j * 5) % 256);
        bm[i][j] = maxv ? 255 : ((seed * 53 + i * 7 + j * 29) % 256);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(busy_o == 0, "R1 busy", busy_o, 0);
    check(done_o == 0, "R1 done", done_o, 0);
    check(err_o == 0, "R1 err", err_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    fill(1, 0); run(1, 0, 0, 0, 0, 0, "R4");
    fill(2, 0); run(3, 0, 0, 0, 0, 0, "R4");
    fill(0, 1); run(2, 0, 0, 0, 0, 0, "R4 max");
    fill(0, 0); run(0, 0, 0, 0, 0, 0, "R2 k0");
    // every single-element corruption
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        fill(3 + i, 0); run(1, 1, i, j, 1, 0, "R5");
      end
    fill(0, 1); run(2, 1, 2, 1, 1 << (CW - 1), 0, "R5 msb");
    fill(0, 1); run(1, 1, 1, 2, 3, 0, "R5 max");
    fill(5, 0); run(4, 1, 0, 2, 'h155, 0, "R5 k4");
    // next start clears err
    fill(6, 0); run(1, 0, 0, 0, 0, 0, "R6 clear");
    // start held high through the run
    fill(7, 0); run(2, 0, 0, 0, 0, 1, "R7");
    fill(7, 0); run(1, 1, 2, 0, 2, 1, "R7 bad");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule